// File: doc/BRIEF.md
# Two-Beat Wide Ternary Search Table

This block holds a small table of 136-bit ternary entries. Each entry has a stored word, a per-bit care mask and a valid flag. A search key does not arrive in one cycle. It comes over a 68-bit bus in two consecutive cycles: the first beat carries the low (even) half and the second beat carries the high (odd) half. A global mask, picked from a file of eight 136-bit masks, is applied together with each entry's own care mask. The lowest-numbered matching entry wins and is reported as a location address. Each entry spans two locations, so a winning entry n is reported as location 2n.

The first beat also selects which global mask applies. The second beat selects a comparand slot, and the complete key is saved into that slot for later use. The saved comparands can be read through a combinational read port. Entries and global masks are loaded through their own write ports. A new search can begin every second cycle. A start request that arrives during a second beat is treated as part of the current search.

Top module: `wide_tcam`

## Requirements
- R1: After reset, res_vld, res_hit and res_loc are 0, every entry is invalid, and every global mask and comparand slot reads as all zeros.
- R2: The cycle with srch_a=1 (while no search is in progress) is beat A: dq supplies key bits [67:0] and gm_sel is sampled. The following cycle is beat B: dq supplies key bits [135:68] and cmp_sel is sampled.
- R3: At the end of beat B, the full 136-bit key is written into the comparand slot chosen by cmp_sel. From the next cycle it is visible on cmp_rdata when cmp_ridx selects that slot.
- R4: A key bit is compared only where both the selected global mask bit and the entry's care bit are 1. Other bits never cause a mismatch.
- R5: When more than one entry matches, the lowest entry index wins. res_loc is twice that index, so bit 0 of res_loc is always 0.
- R6: res_vld is 1 for exactly the one cycle after beat B. res_hit and res_loc change only at that point and then hold their values.
- R7: When no entry matches, res_hit is 0 and res_loc is 0.
- R8: An invalid entry never matches. Writing an entry with ent_valid=0 makes it invalid.
- R9: srch_a is ignored during beat B, so searches start at most once every two cycles.
- R10: A search compares against the table contents as they stand during beat B. An entry write in that same cycle affects only later searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_we | input | 1 | Entry write enable |
| ent_addr | input | 4 | Entry index to write |
| ent_valid | input | 1 | Valid flag written with the entry |
| ent_data | input | 136 | Entry word |
| ent_care | input | 136 | Entry care mask (1 = compare this bit) |
| gm_we | input | 1 | Global mask write enable |
| gm_widx | input | 3 | Global mask slot to write |
| gm_wdata | input | 136 | Global mask value (1 = compare this bit) |
| srch_a | input | 1 | Beat A strobe that starts a search |
| dq | input | 68 | Key half: even half in beat A, odd half in beat B |
| gm_sel | input | 3 | Global mask slot, sampled in beat A |
| cmp_sel | input | 3 | Comparand slot, sampled in beat B |
| cmp_ridx | input | 3 | Comparand read index |
| cmp_rdata | output | 136 | Comparand slot contents |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 1 | Match found |
| res_loc | output | 5 | Winning location address (even) |

## Verification
The first patterns are directed. The same key sits in several entries, which separates lowest-index priority from any other order. Two entries differ only in a bit that one of them masks locally, which shows that the care mask is honoured. Global masks that clear the whole key, or only its odd half, show that the mask is taken from the slot chosen in beat A and applied to the correct half. Back-to-back start requests and an entry write that coincides with beat B expose errors in beat tracking and in read-before-write ordering. A random phase then draws keys from a small pool, with random care masks and random mask writes, and compares every cycle against a behavioural model to catch wrong half assembly or wrong comparand slot selection.

// File: rtl/wtcam_pkg.sv
package wtcam_pkg;
  localparam int HALF_W = 68;
  localparam int KEY_W  = 2 * HALF_W;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [KEY_W-1:0]  key_t;
endpackage

// File: rtl/wtcam_pair_file.sv
// Register file of 136-bit even/odd pairs, one write port, one read port.
module wtcam_pair_file
  import wtcam_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  half_t         wr_even,
  input  half_t         wr_odd,
  input  logic [IW-1:0] rd_idx,
  output key_t          rd_data
);
  key_t slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_en;
    key_t slot_d;
    always_comb begin
      slot_en = wr_en && (wr_idx == IW'(g));
      slot_d  = {wr_odd, wr_even};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= slot_d;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/wtcam_entry_array.sv
// Entry storage with one ternary comparator per entry.
module wtcam_entry_array
  import wtcam_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_valid,
  input  key_t             wr_data,
  input  key_t             wr_care,
  input  key_t             srch_key,
  input  key_t             gmask,
  output logic [DEPTH-1:0] match
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic vld_q;
    key_t data_q;
    key_t care_q;
    logic ent_en;
    key_t diff;

    always_comb begin
      ent_en = wr_en && (wr_addr == AW'(e));
      diff   = (srch_key ^ data_q) & care_q & gmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        data_q <= '0;
        care_q <= '0;
      end else if (ent_en) begin
        vld_q  <= wr_valid;
        data_q <= wr_data;
        care_q <= wr_care;
      end
    end

    assign match[e] = vld_q && (diff == '0);
  end
endmodule

// File: rtl/wtcam_prio_enc.sv
// Lowest-index-wins priority encoder.
module wtcam_prio_enc #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/wide_tcam.sv
module wide_tcam
  import wtcam_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int GM_N  = 8,
  parameter int CMP_N = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LOC_W = AW + 1,
  localparam int GIW   = $clog2(GM_N),
  localparam int CIW   = $clog2(CMP_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_we,
  input  logic [AW-1:0]     ent_addr,
  input  logic              ent_valid,
  input  logic [KEY_W-1:0]  ent_data,
  input  logic [KEY_W-1:0]  ent_care,
  input  logic              gm_we,
  input  logic [GIW-1:0]    gm_widx,
  input  logic [KEY_W-1:0]  gm_wdata,
  input  logic              srch_a,
  input  logic [HALF_W-1:0] dq,
  input  logic [GIW-1:0]    gm_sel,
  input  logic [CIW-1:0]    cmp_sel,
  input  logic [CIW-1:0]    cmp_ridx,
  output logic [KEY_W-1:0]  cmp_rdata,
  output logic              res_vld,
  output logic              res_hit,
  output logic [LOC_W-1:0]  res_loc
);
  // beat tracking
  logic           beat_b_q, beat_b_d;
  logic           cap_a;
  half_t          even_q;
  logic [GIW-1:0] gsel_q;

  always_comb begin
    cap_a    = srch_a && !beat_b_q;
    beat_b_d = cap_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_b_q <= 1'b0;
    else        beat_b_q <= beat_b_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q <= '0;
      gsel_q <= '0;
    end else if (cap_a) begin
      even_q <= dq;
      gsel_q <= gm_sel;
    end
  end

  // mask and comparand files
  key_t gmask;
  key_t srch_key;

  assign srch_key = {dq, even_q};

  wtcam_pair_file #(.SLOTS(GM_N)) u_gmask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (gm_we),
    .wr_idx  (gm_widx),
    .wr_even (gm_wdata[HALF_W-1:0]),
    .wr_odd  (gm_wdata[KEY_W-1:HALF_W]),
    .rd_idx  (gsel_q),
    .rd_data (gmask)
  );

  wtcam_pair_file #(.SLOTS(CMP_N)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (beat_b_q),
    .wr_idx  (cmp_sel),
    .wr_even (even_q),
    .wr_odd  (dq),
    .rd_idx  (cmp_ridx),
    .rd_data (cmp_rdata)
  );

  // match and priority
  logic [DEPTH-1:0] match;
  logic             win_any;
  logic [AW-1:0]    win_idx;

  wtcam_entry_array #(.DEPTH(DEPTH)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ent_we),
    .wr_addr  (ent_addr),
    .wr_valid (ent_valid),
    .wr_data  (ent_data),
    .wr_care  (ent_care),
    .srch_key (srch_key),
    .gmask    (gmask),
    .match    (match)
  );

  wtcam_prio_enc #(.N(DEPTH)) u_prio (
    .req (match),
    .any (win_any),
    .idx (win_idx)
  );

  // result registers
  logic             hit_q, hit_d;
  logic [LOC_W-1:0] loc_q, loc_d;
  logic             vld_q;

  always_comb begin
    hit_d = win_any;
    loc_d = win_any ? {win_idx, 1'b0} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= beat_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      loc_q <= '0;
    end else if (beat_b_q) begin
      hit_q <= hit_d;
      loc_q <= loc_d;
    end
  end

  assign res_vld = vld_q;
  assign res_hit = hit_q;
  assign res_loc = loc_q;
endmodule

// File: rtl/wtcam_chk.sv
module wtcam_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          beat_b,
  input logic          res_vld,
  input logic          res_hit,
  input logic [LW-1:0] res_loc
);
  // R9
  beat_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_b |=> !beat_b);

  // R6
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_b |=> res_vld);

  // R6
  result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(beat_b));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> ($stable(res_hit) && $stable(res_loc)));

  // R5
  loc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_loc[0] == 1'b0);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_loc == '0));
endmodule

bind wide_tcam wtcam_chk #(.LW(LOC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .beat_b  (beat_b_q),
  .res_vld (res_vld),
  .res_hit (res_hit),
  .res_loc (res_loc)
);

// File: tb/wide_tcam_bench.sv
module wide_tcam_bench;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int LW    = 5;
  localparam int KW    = 136;
  localparam int HW    = 68;

  logic          clk;
  logic          rst_n;
  logic          ent_we;
  logic [AW-1:0] ent_addr;
  logic          ent_valid;
  logic [KW-1:0] ent_data, ent_care;
  logic          gm_we;
  logic [2:0]    gm_widx;
  logic [KW-1:0] gm_wdata;
  logic          srch_a;
  logic [HW-1:0] dq;
  logic [2:0]    gm_sel, cmp_sel, cmp_ridx;
  logic [KW-1:0] cmp_rdata;
  logic          res_vld, res_hit;
  logic [LW-1:0] res_loc;

  int n_chk;
  int n_bad;

  wide_tcam u_wide_tcam (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_addr(ent_addr),
    .ent_valid(ent_valid), .ent_data(ent_data), .ent_care(ent_care),
    .gm_we(gm_we), .gm_widx(gm_widx), .gm_wdata(gm_wdata),
    .srch_a(srch_a), .dq(dq), .gm_sel(gm_sel), .cmp_sel(cmp_sel),
    .cmp_ridx(cmp_ridx), .cmp_rdata(cmp_rdata),
    .res_vld(res_vld), .res_hit(res_hit), .res_loc(res_loc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  logic [KW-1:0] m_data [DEPTH];
  logic [KW-1:0] m_care [DEPTH];
  bit            m_val  [DEPTH];
  logic [KW-1:0] m_gm   [8];
  logic [KW-1:0] m_cmp  [8];
  bit            m_inb;
  logic [HW-1:0] m_even;
  logic [2:0]    m_gs;
  bit            e_vld, e_hit;
  logic [LW-1:0] e_loc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        m_val[i] = 0; m_data[i] = '0; m_care[i] = '0;
      end
      for (int i = 0; i < 8; i++) begin
        m_gm[i] = '0; m_cmp[i] = '0;
      end
      m_inb = 0; m_even = '0; m_gs = '0;
      e_vld = 0; e_hit = 0; e_loc = '0;
    end else begin
      logic [KW-1:0] k;
      bit found;
      int wi;
      bit start;
      e_vld = m_inb;
      if (m_inb) begin
        k = {dq, m_even};
        found = 0; wi = 0;
        for (int i = 0; i < DEPTH; i++) begin
          if (!found && m_val[i] && (((k ^ m_data[i]) & m_care[i] & m_gm[m_gs]) == '0)) begin
            found = 1; wi = i;
          end
        end
        e_hit = found;
        e_loc = found ? LW'(2 * wi) : '0;
        m_cmp[cmp_sel] = k;
      end
      if (ent_we) begin
        m_val[ent_addr] = ent_valid;
        m_data[ent_addr] = ent_data;
        m_care[ent_addr] = ent_care;
      end
      if (gm_we) m_gm[gm_widx] = gm_wdata;
      start = srch_a && !m_inb;
      if (start) begin
        m_even = dq; m_gs = gm_sel;
      end
      m_inb = start;
    end
  end

  task automatic check(input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6/R9 res_vld", KW'(res_vld), KW'(e_vld));
      check("R4/R8/R10 res_hit", KW'(res_hit), KW'(e_hit));
      check("R2/R5/R7 res_loc", KW'(res_loc), KW'(e_loc));
      check("R3 cmp_rdata", cmp_rdata, m_cmp[cmp_ridx]);
    end
  end

  function automatic logic [KW-1:0] rkey();
    logic [159:0] t;
    t = {$urandom, $urandom, $urandom, $urandom, $urandom};
    return t[KW-1:0];
  endfunction

  task automatic idle_inputs();
    ent_we = 0; ent_addr = '0; ent_valid = 0; ent_data = '0; ent_care = '0;
    gm_we = 0; gm_widx = '0; gm_wdata = '0;
    srch_a = 0; dq = '0; gm_sel = '0; cmp_sel = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic put_entry(input int a, input bit v, input logic [KW-1:0] d, input logic [KW-1:0] c);
    ent_we = 1; ent_addr = AW'(a); ent_valid = v; ent_data = d; ent_care = c;
    step();
  endtask

  task automatic put_gmask(input int i, input logic [KW-1:0] m);
    gm_we = 1; gm_widx = 3'(i); gm_wdata = m;
    step();
  endtask

  task automatic search(input logic [KW-1:0] k, input int g, input int c);
    srch_a = 1; dq = k[HW-1:0]; gm_sel = 3'(g);
    step();
    dq = k[KW-1:HW]; cmp_sel = 3'(c); cmp_ridx = 3'(c);
    step();
  endtask

  logic [KW-1:0] kp, kq, ones;

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    ones = '1;
    rst_n = 0; cmp_ridx = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 res_vld", KW'(res_vld), '0);
    check("R1 res_hit", KW'(res_hit), '0);
    check("R1 res_loc", KW'(res_loc), '0);
    check("R1 cmp_rdata", cmp_rdata, '0);
    step();
    // R1/R8: empty table misses even with all-zero global mask
    search(rkey(), 0, 1);
    step();

    kp = rkey(); kq = rkey();
    put_gmask(0, ones);
    put_gmask(1, {{HW{1'b0}}, {HW{1'b1}}});
    put_gmask(2, '0);
    put_entry(3, 1, kp, ones);
    put_entry(5, 1, kp, ones);
    put_entry(7, 1, kp ^ (KW'(1) << 100), ones & ~(KW'(1) << 100));
    put_entry(9, 1, kp ^ (KW'(1) << 10), ones);

    search(kp, 0, 2);                    // R5: entries 3,5,7 match -> loc 6
    search(kp ^ (KW'(1) << 100), 0, 3);  // R4: only 7 (bit masked locally) -> loc 14
    search(kp ^ (KW'(1) << 10), 0, 4);   // R2: low-half change -> entry 9, loc 18
    search(rkey(), 0, 5);                // R7: miss
    search(kq, 2, 6);                    // R4: all-zero global mask -> entry 3
    search({~kp[KW-1:HW], kp[HW-1:0]}, 1, 7); // R2/R4: odd half ignored -> entry 3
    put_entry(3, 0, kp, ones);           // R8: invalidate
    search(kp, 0, 0);                    // R8: now entry 5 -> loc 10
    put_entry(15, 1, kq, ones);
    search(kq, 0, 1);                    // R5: last entry -> loc 30
    // R9: srch_a held through beat B
    srch_a = 1; dq = kq[HW-1:0]; gm_sel = 3'd0;
    step();
    srch_a = 1; dq = kq[KW-1:HW]; cmp_sel = 3'd2; cmp_ridx = 3'd2;
    step();
    step(); step();
    // R10: entry write coincides with beat B
    srch_a = 1; dq = kq[HW-1:0]; gm_sel = 3'd0;
    step();
    dq = kq[KW-1:HW]; cmp_sel = 3'd3;
    ent_we = 1; ent_addr = '0; ent_valid = 1; ent_data = kq; ent_care = ones;
    step();
    search(kq, 0, 4);                    // R10: now entry 0 wins -> loc 0
    step();

    // random phase against the model
    for (int it = 0; it < 400; it++) begin
      int sel;
      logic [KW-1:0] k;
      sel = int'($urandom_range(0, 9));
      cmp_ridx = 3'($urandom_range(0, 7));
      k = ($urandom_range(0, 1) == 1) ? kp : kq;
      if (sel < 2) put_entry(int'($urandom_range(0, DEPTH - 1)), ($urandom_range(0, 4) != 0),
                             k ^ (KW'(1) << $urandom_range(0, KW - 1)), ones & ~rkey() | rkey());
      else if (sel == 2) put_gmask(int'($urandom_range(0, 7)), rkey() | rkey());
      else if (sel == 3) step();
      else search(($urandom_range(0, 3) == 0) ? rkey() : k ^ (KW'(1) << $urandom_range(0, KW - 1)),
                  int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    end
    step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule